// File: doc/BRIEF.md
# Branch and Call Next-PC Unit

This unit resolves the control-transfer group of an 8-bit processor: absolute jumps, relative jumps and subroutine calls, each in an unconditional and a conditional form. The sequencer presents one request at a time. A request holds the address of the instruction's first byte, its opcode, the two operand bytes the fetch stage has already collected, and the current flag byte. One clock later the unit returns the next program counter and the number of machine cycles the instruction costs. For a call that is taken, it also raises a one-cycle request asking the stack logic to save a return address.

For an absolute form the two operand bytes are a little-endian 16-bit target. For a relative form the first operand byte is a signed displacement, counted from the address that follows the two-byte instruction. A conditional form that is not taken moves on to the next sequential instruction, and its cycle cost is different from the taken path. The unit leaves alone any opcode outside this group: it flags the opcode as unrecognised and leaves the program counter unchanged, so the sequencer can send that opcode to another execution path.

Top module: `brpc_unit`

## Requirements
- R1: While reset is active, and up to the first accepted request, every output is zero.
- R2: A request sampled with `inValid` high produces its results, with `outValid` high, on the following clock edge. The same edge is the only one on which `outValid` is high for that request. While no request is present, `nextPc`, `cycles`, `isBranch` and `pushAddr` keep their values. `pushValid` is never high without `outValid`.
- R3: Opcode 0xC3 sets `nextPc` to {`immHi`,`immLo`} and reports 10 cycles.
- R4: The eight opcodes that match 0xC2 under mask 0xC7 jump to {`immHi`,`immLo`} when their condition holds. Otherwise they move to `curPc`+3. Both paths report 10 cycles.
- R5: For the 0xC2/0xC4 groups the condition code is opcode bits 5:3. The codes test the flag byte as follows: 0 = Z clear, 1 = Z set, 2 = C clear, 3 = C set, 4 = P/V clear, 5 = P/V set, 6 = S clear, 7 = S set. The flag bit positions are S = bit 7, Z = bit 6, P/V = bit 2 and C = bit 0.
- R6: Opcode 0x18 sets `nextPc` to `curPc`+2 plus the sign-extended `immLo` and reports 12 cycles.
- R7: Opcodes 0x20, 0x28, 0x30 and 0x38 take their condition code from bits 5:3 of (opcode − 0x20). This gives codes 0 to 3 only, with the meanings listed in R5. When the condition is taken, `nextPc` is `curPc`+2 plus the sign-extended `immLo`, at 12 cycles. When it is not taken, `nextPc` is `curPc`+2, at 7 cycles.
- R8: Opcode 0xCD raises `pushValid` with `pushAddr` = `curPc`+3, sets `nextPc` to {`immHi`,`immLo`} and reports 17 cycles.
- R9: The eight opcodes that match 0xC4 under mask 0xC7 behave as R8 when their condition holds. Otherwise they give no push and move to `curPc`+3 at 10 cycles.
- R10: All program counter arithmetic wraps modulo 65536.
- R11: Any other opcode gives `isBranch` = 0, `nextPc` = `curPc`, no push and 0 cycles.
- R12: `pushValid` is a one-cycle pulse for each taken call. It is never raised for jumps, for conditional calls that are not taken, or for unrecognised opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| curPc | input | 16 | Address of the instruction's first byte |
| opcode | input | 8 | Instruction opcode |
| immLo | input | 8 | First operand byte (target low byte or displacement) |
| immHi | input | 8 | Second operand byte (target high byte) |
| flags | input | 8 | Processor flag byte |
| outValid | output | 1 | Results for the previous request are valid |
| isBranch | output | 1 | Opcode belonged to the control-transfer group |
| nextPc | output | 16 | Resolved next program counter |
| pushValid | output | 1 | One-cycle request to save a return address |
| pushAddr | output | 16 | Return address to save |
| cycles | output | 5 | Machine-cycle cost of the instruction |

## Verification
The cases that are hardest to reach from the ports are the conditional forms. In each one the flag byte has to both satisfy and fail the condition that the opcode selects. For the relative group the code is also offset, so a bit-selection error would show up only for particular pairs of opcode and flag. The stimulus walks every condition code of all three conditional groups, once with its flag set and once with it clear. Random requests are then drawn mostly from the branch opcodes, with random flags and operands. Directed requests place the program counter at the top and bottom of the address space, with extreme displacements, so that the wrap and the sign extension are exercised.

// File: rtl/brpc_pkg.sv
package brpc_pkg;
  localparam int PC_W   = 16;
  localparam int BYTE_W = 8;
  localparam int CYC_W  = 5;
  localparam int CC_W   = 3;

  localparam logic [CYC_W-1:0] CYC_ABS      = CYC_W'(10);
  localparam logic [CYC_W-1:0] CYC_REL_TAKE = CYC_W'(12);
  localparam logic [CYC_W-1:0] CYC_REL_SKIP = CYC_W'(7);
  localparam logic [CYC_W-1:0] CYC_CALL     = CYC_W'(17);
  localparam logic [CYC_W-1:0] CYC_NONE     = '0;

  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_PV = 2;
  localparam int FLAG_C  = 0;

  typedef enum logic [2:0] {
    SEL_KEEP, SEL_ABS, SEL_REL, SEL_SKIP2, SEL_SKIP3
  } nextSel_e;

  typedef enum logic [2:0] {
    K_NONE, K_JP, K_JPCC, K_JR, K_JRCC, K_CALL, K_CALLCC
  } kind_e;

  typedef struct packed {
    logic             isBranch;
    nextSel_e         sel;
    logic             push;
    logic [CYC_W-1:0] cyc;
  } ctrlStrobe_t;

  // Condition code pairs (2k, 2k+1) test one flag: clear, then set.
  function automatic int condFlagBit(input int code);
    case (code / 2)
      0:       return FLAG_Z;
      1:       return FLAG_C;
      2:       return FLAG_PV;
      default: return FLAG_S;
    endcase
  endfunction
endpackage

// File: rtl/brpc_cond.sv
module brpc_cond
  import brpc_pkg::*;
#(
  parameter int FLAG_W = BYTE_W,
  parameter int NUM_CC = 8,
  localparam int SEL_W = $clog2(NUM_CC)
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [SEL_W-1:0]  ccSel,
  output logic              condTrue
);
  logic [NUM_CC-1:0] truthVec;

  for (genvar i = 0; i < NUM_CC; i++) begin : g_cc
    localparam int FB = condFlagBit(i);
    if (i % 2 == 1) begin : g_set
      assign truthVec[i] = flags[FB];
    end else begin : g_clr
      assign truthVec[i] = ~flags[FB];
    end
  end

  assign condTrue = truthVec[ccSel];
endmodule

// File: rtl/brpc_ctrl.sv
module brpc_ctrl
  import brpc_pkg::*;
#(
  parameter int OP_W = BYTE_W
) (
  input  logic [OP_W-1:0] opcode,
  input  logic            condTrue,
  output logic [CC_W-1:0] ccSel,
  output ctrlStrobe_t     strobe
);
  localparam logic [OP_W-1:0] OP_JP      = OP_W'(8'hC3);
  localparam logic [OP_W-1:0] OP_JR      = OP_W'(8'h18);
  localparam logic [OP_W-1:0] OP_CALL    = OP_W'(8'hCD);
  localparam logic [OP_W-1:0] CC_MASK    = OP_W'(8'hC7);
  localparam logic [OP_W-1:0] JPCC_BASE  = OP_W'(8'hC2);
  localparam logic [OP_W-1:0] CALLCC_BASE = OP_W'(8'hC4);
  localparam logic [OP_W-1:0] REL_MASK   = OP_W'(8'hE7);
  localparam logic [OP_W-1:0] REL_BASE   = OP_W'(8'h20);

  kind_e           kind;
  logic [OP_W-1:0] relOp;

  always_comb begin
    if (opcode == OP_JP)                            kind = K_JP;
    else if (opcode == OP_JR)                       kind = K_JR;
    else if (opcode == OP_CALL)                     kind = K_CALL;
    else if ((opcode & CC_MASK) == JPCC_BASE)       kind = K_JPCC;
    else if ((opcode & CC_MASK) == CALLCC_BASE)     kind = K_CALLCC;
    else if ((opcode & REL_MASK) == REL_BASE)       kind = K_JRCC;
    else                                            kind = K_NONE;
  end

  // Relative conditionals reuse the absolute code table shifted by 0x20.
  assign relOp = opcode - REL_BASE;
  assign ccSel = (kind == K_JRCC) ? relOp[5:3] : opcode[5:3];

  always_comb begin
    strobe = '{isBranch: 1'b1, sel: SEL_KEEP, push: 1'b0, cyc: CYC_NONE};
    unique case (kind)
      K_JP: begin
        strobe.sel = SEL_ABS;
        strobe.cyc = CYC_ABS;
      end
      K_JPCC: begin
        strobe.sel = condTrue ? SEL_ABS : SEL_SKIP3;
        strobe.cyc = CYC_ABS;
      end
      K_JR: begin
        strobe.sel = SEL_REL;
        strobe.cyc = CYC_REL_TAKE;
      end
      K_JRCC: begin
        strobe.sel = condTrue ? SEL_REL : SEL_SKIP2;
        strobe.cyc = condTrue ? CYC_REL_TAKE : CYC_REL_SKIP;
      end
      K_CALL: begin
        strobe.sel  = SEL_ABS;
        strobe.push = 1'b1;
        strobe.cyc  = CYC_CALL;
      end
      K_CALLCC: begin
        strobe.sel  = condTrue ? SEL_ABS : SEL_SKIP3;
        strobe.push = condTrue;
        strobe.cyc  = condTrue ? CYC_CALL : CYC_ABS;
      end
      default: begin
        strobe.isBranch = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/brpc_datapath.sv
module brpc_datapath
  import brpc_pkg::*;
#(
  parameter int ADDR_W = PC_W,
  localparam int HALF_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [HALF_W-1:0] immLo,
  input  logic [HALF_W-1:0] immHi,
  input  ctrlStrobe_t       strobe,
  output logic              outValid,
  output logic              isBranch,
  output logic [ADDR_W-1:0] nextPc,
  output logic              pushValid,
  output logic [ADDR_W-1:0] pushAddr,
  output logic [CYC_W-1:0]  cycles
);
  logic [ADDR_W-1:0] absTgt, relTgt, seq2, seq3, dispExt, pcSel;

  assign absTgt  = {immHi, immLo};
  assign dispExt = {{(ADDR_W-HALF_W){immLo[HALF_W-1]}}, immLo};
  assign seq2    = curPc + ADDR_W'(2);
  assign seq3    = curPc + ADDR_W'(3);
  assign relTgt  = seq2 + dispExt;

  always_comb begin
    unique case (strobe.sel)
      SEL_ABS:   pcSel = absTgt;
      SEL_REL:   pcSel = relTgt;
      SEL_SKIP2: pcSel = seq2;
      SEL_SKIP3: pcSel = seq3;
      default:   pcSel = curPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      pushValid <= 1'b0;
      isBranch  <= 1'b0;
      nextPc    <= '0;
      pushAddr  <= '0;
      cycles    <= '0;
    end else begin
      outValid  <= inValid;
      pushValid <= inValid & strobe.push;
      if (inValid) begin
        isBranch <= strobe.isBranch;
        nextPc   <= pcSel;
        cycles   <= strobe.cyc;
        if (strobe.push) pushAddr <= seq3;
      end
    end
  end
endmodule

// File: rtl/brpc_unit.sv
module brpc_unit
  import brpc_pkg::*;
#(
  parameter int ADDR_W = PC_W,
  parameter int OP_W   = BYTE_W,
  parameter int CNT_W  = CYC_W,
  localparam int HALF_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [OP_W-1:0]   opcode,
  input  logic [HALF_W-1:0] immLo,
  input  logic [HALF_W-1:0] immHi,
  input  logic [OP_W-1:0]   flags,
  output logic              outValid,
  output logic              isBranch,
  output logic [ADDR_W-1:0] nextPc,
  output logic              pushValid,
  output logic [ADDR_W-1:0] pushAddr,
  output logic [CNT_W-1:0]  cycles
);
  logic [CC_W-1:0] ccSel;
  logic            condTrue;
  ctrlStrobe_t     strobe;

  brpc_ctrl #(.OP_W(OP_W)) u_ctrl (
    .opcode  (opcode),
    .condTrue(condTrue),
    .ccSel   (ccSel),
    .strobe  (strobe)
  );

  brpc_cond #(.FLAG_W(OP_W), .NUM_CC(1 << CC_W)) u_cond (
    .flags   (flags),
    .ccSel   (ccSel),
    .condTrue(condTrue)
  );

  brpc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .curPc    (curPc),
    .immLo    (immLo),
    .immHi    (immHi),
    .strobe   (strobe),
    .outValid (outValid),
    .isBranch (isBranch),
    .nextPc   (nextPc),
    .pushValid(pushValid),
    .pushAddr (pushAddr),
    .cycles   (cycles)
  );
endmodule

// File: rtl/brpc_checker.sv
module brpc_checker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [ADDR_W-1:0] curPc,
  input logic              outValid,
  input logic              isBranch,
  input logic [ADDR_W-1:0] nextPc,
  input logic              pushValid,
  input logic [ADDR_W-1:0] pushAddr,
  input logic [CNT_W-1:0]  cycles
);
  logic [ADDR_W-1:0] prevPc, prevPlus2, prevPlus3;
  logic              prevIn;

  always_ff @(posedge clk) begin
    prevPc <= curPc;
    prevIn <= inValid & rstN;
  end
  assign prevPlus2 = prevPc + ADDR_W'(2);
  assign prevPlus3 = prevPc + ADDR_W'(3);

  a_r2_out_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> prevIn);

  a_r2_push_inside_out: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> outValid);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(nextPc) && $stable(cycles) && $stable(pushAddr)));

  a_r12_return_addr: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> pushAddr == prevPlus3);

  a_r8_call_cost: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> (cycles == CNT_W'(17) && isBranch));

  a_r7_rel_skip: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && isBranch && cycles == CNT_W'(7)) |-> nextPc == prevPlus2);

  a_r11_foreign_op: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !isBranch) |-> (nextPc == prevPc && cycles == '0 && !pushValid));
endmodule

bind brpc_unit brpc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .curPc    (curPc),
  .outValid (outValid),
  .isBranch (isBranch),
  .nextPc   (nextPc),
  .pushValid(pushValid),
  .pushAddr (pushAddr),
  .cycles   (cycles)
);

// File: tb/tb_brpc_unit.sv
`timescale 1ns/1ps
module tb_brpc_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] curPc = '0;
  logic [7:0]  opcode = '0, immLo = '0, immHi = '0, flags = '0;
  logic        outValid, isBranch, pushValid;
  logic [15:0] nextPc, pushAddr;
  logic [4:0]  cycles;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  brpc_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .curPc(curPc),
    .opcode(opcode), .immLo(immLo), .immHi(immHi), .flags(flags),
    .outValid(outValid), .isBranch(isBranch), .nextPc(nextPc),
    .pushValid(pushValid), .pushAddr(pushAddr), .cycles(cycles)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Flag bits: S=7, Z=6, P/V=2, C=0; code pairs test Z, C, P/V, S (clear, set).
  function automatic bit condHolds(input int code, input logic [7:0] fl);
    logic b;
    case (code / 2)
      0: b = fl[6];
      1: b = fl[0];
      2: b = fl[2];
      default: b = fl[7];
    endcase
    return (code % 2 == 1) ? b : !b;
  endfunction

  task automatic model(input logic [7:0] op, input logic [15:0] pc,
                       input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] fl,
                       output bit br, output logic [15:0] np, output bit pu,
                       output logic [15:0] pa, output logic [4:0] cy, output string tag);
    logic [15:0] tgt, rel;
    tgt = {hi, lo};
    rel = pc + 16'd2 + {{8{lo[7]}}, lo};
    br = 1; pu = 0; pa = pc + 16'd3;
    if (op == 8'hC3) begin np = tgt; cy = 10; tag = "R3"; end
    else if (op == 8'h18) begin np = rel; cy = 12; tag = "R6"; end
    else if (op == 8'hCD) begin np = tgt; cy = 17; pu = 1; tag = "R8/R12"; end
    else if ((op & 8'hC7) == 8'hC2) begin
      np = condHolds(int'(op[5:3]), fl) ? tgt : pc + 16'd3; cy = 10; tag = "R4/R5";
    end else if ((op & 8'hC7) == 8'hC4) begin
      if (condHolds(int'(op[5:3]), fl)) begin np = tgt; cy = 17; pu = 1; end
      else begin np = pc + 16'd3; cy = 10; end
      tag = "R9/R5/R12";
    end else if (op == 8'h20 || op == 8'h28 || op == 8'h30 || op == 8'h38) begin
      if (condHolds(int'(op[4:3]), fl)) begin np = rel; cy = 12; end
      else begin np = pc + 16'd2; cy = 7; end
      tag = "R7";
    end else begin
      br = 0; np = pc; cy = 0; tag = "R11";
    end
  endtask

  task automatic runOp(input logic [7:0] op, input logic [15:0] pc, input logic [7:0] lo,
                       input logic [7:0] hi, input logic [7:0] fl, input string note);
    bit br, pu; logic [15:0] np, pa; logic [4:0] cy; string tag;
    model(op, pc, lo, hi, fl, br, np, pu, pa, cy, tag);
    @(negedge clk);
    opcode = op; curPc = pc; immLo = lo; immHi = hi; flags = fl; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " ", note}, {outValid, isBranch, nextPc, pushValid, pushValid ? pushAddr : 16'h0, cycles},
          {1'b1, br, np, pu, pu ? pa : 16'h0, cy});
  endtask

  task automatic idleCheck();
    logic [15:0] np0, pa0; logic [4:0] cy0;
    np0 = nextPc; pa0 = pushAddr; cy0 = cycles;
    curPc = curPc ^ 16'h5A5A; opcode = 8'hCD;
    @(negedge clk);
    check("R2 idle hold", {outValid, pushValid, nextPc, pushAddr, cycles},
          {1'b0, 1'b0, np0, pa0, cy0});
  endtask

  initial begin
    logic [7:0] brOps [12];
    int unused;
    brOps = '{8'hC3, 8'h18, 8'hCD, 8'hC2, 8'hD2, 8'hFA, 8'hC4, 8'hEC, 8'h20, 8'h28, 8'h30, 8'h38};
    unused = $urandom(32'h1F0E);
    repeat (3) @(negedge clk);
    check("R1 reset", {outValid, isBranch, nextPc, pushValid, pushAddr, cycles}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset idle", {outValid, isBranch, nextPc, pushValid, pushAddr, cycles}, '0);

    runOp(8'hC3, 16'h1000, 8'h34, 8'h12, 8'h00, "jump absolute");
    idleCheck();
    runOp(8'hCD, 16'h2000, 8'h78, 8'h56, 8'hFF, "call");
    idleCheck();
    for (int c = 0; c < 8; c++) begin
      runOp(8'hC2 | 8'(c << 3), 16'h4000, 8'hEF, 8'hBE, 8'h00, "jp cc flags clear");
      runOp(8'hC2 | 8'(c << 3), 16'h4000, 8'hEF, 8'hBE, 8'hFF, "jp cc flags set");
      runOp(8'hC4 | 8'(c << 3), 16'h5000, 8'h00, 8'h90, 8'h00, "call cc flags clear");
      runOp(8'hC4 | 8'(c << 3), 16'h5000, 8'h00, 8'h90, 8'hFF, "call cc flags set");
    end
    for (int c = 0; c < 4; c++) begin
      runOp(8'h20 + 8'(c << 3), 16'h3000, 8'h10, 8'h00, 8'h00, "jr cc clear");
      runOp(8'h20 + 8'(c << 3), 16'h3000, 8'hF0, 8'h00, 8'hFF, "jr cc set");
    end
    runOp(8'h18, 16'hFFFE, 8'h05, 8'h00, 8'h00, "R10 forward wrap");
    runOp(8'h18, 16'h0001, 8'h80, 8'h00, 8'h00, "R10 back wrap -128");
    runOp(8'h18, 16'h1234, 8'h7F, 8'h00, 8'h00, "max forward");
    runOp(8'hCD, 16'hFFFE, 8'h00, 8'h80, 8'h00, "R10 return wrap");
    runOp(8'hC2, 16'hFFFF, 8'h00, 8'h00, 8'h40, "R10 skip3 wrap");
    runOp(8'h38, 16'hFFFF, 8'h00, 8'h00, 8'h00, "R10 skip2 wrap");
    runOp(8'h00, 16'hABCD, 8'h11, 8'h22, 8'hFF, "nop");
    runOp(8'hC9, 16'h0100, 8'h11, 8'h22, 8'hFF, "other");
    runOp(8'h40, 16'h0100, 8'h11, 8'h22, 8'hFF, "other");
    idleCheck();
    for (int i = 0; i < 600; i++) begin
      logic [7:0] op;
      op = ($urandom % 10 < 8) ? brOps[$urandom % 12] : 8'($urandom);
      runOp(op, 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "random");
      if (i % 50 == 0) idleCheck();
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule